// File: doc/BRIEF.md
# Seconds-Aligned Posted Write Controller for a Real-Time-Clock Domain

This block carries register writes from a fast core clock domain into a slow real-time-clock domain. That domain only accepts changes on its once-per-second event. The core side presents a write strobe, a 2-bit target select and a data word. Each write is captured into a holding register for its target. The write is then handed across the clock boundary with a toggle request. The RTC side commits the data only on a cycle where the seconds tick is high. An acknowledge toggle returns to the core side and retires the write. The delay from a core write to its commit can reach one full second.

There are four targets: the time-count register, the alarm register, the control register and the auxiliary switch register. Each target has its own pending bit, and all four can be in flight at the same time. A second write to a target whose pending bit is set is dropped. Bit `PDN_BIT` of the control register powers the oscillator down. While it is set, writes to the other three registers are retired without effect. After it clears, time-count and alarm writes wait until the oscillator has shown one seconds tick while running.

Top module: `rtc_posted_write`

## Requirements
- R1: After reset, the time-count, alarm and switch registers read zero. The control register reads zero except bit `PDN_BIT`, which is one, so `osc_down` is 1 and `osc_ready` is 0. `pend_mask` and `wr_busy` are 0.
- R2: A write is accepted when `wr_en` is high and the selected pending bit is clear. The pending bit for the target is then set in the next core cycle. `wr_busy` is high exactly when any `pend_mask` bit is set.
- R3: A write to a target whose pending bit is set is ignored. The value committed for that target is the first posted value.
- R4: The four RTC-domain registers change only on a clock edge where `sec_tick` is high. A posted write remains pending, with its register unchanged, for as long as no tick occurs. Its pending bit clears within a few core cycles after the tick that retires it.
- R5: While the committed control register has bit `PDN_BIT` set, a tick retires posted writes to the time-count, alarm and switch registers without changing them. This also holds on the tick that commits a control write clearing the bit.
- R6: `osc_ready` is set by the first tick that finds `PDN_BIT` clear. It is cleared by a tick that commits `PDN_BIT` set. Time-count and alarm writes commit only on a tick where `osc_ready` was already 1. Otherwise they stay pending while powered up.
- R7: Writes to different targets may be pending at the same time, and a single tick commits all of them.
- R8: `wr_sel` encodes 0 as time-count, 1 as alarm, 2 as control and 3 as switch. `pend_mask` bit n belongs to target n.
- R9: Writes to the control and switch registers need no prior tick while running. A control write commits on the first tick after its request arrives, even while powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock |
| rst_core_n | input | 1 | Synchronous active-low reset, core domain |
| wr_en | input | 1 | Write strobe, one core cycle per write |
| wr_sel | input | 2 | Target select (R8 encoding) |
| wr_data | input | DW | Write data |
| pend_mask | output | 4 | Per-target pending bits |
| wr_busy | output | 1 | OR of the pending bits |
| clk_rtc | input | 1 | RTC oscillator clock |
| rst_rtc_n | input | 1 | Synchronous active-low reset, RTC domain |
| sec_tick | input | 1 | One-cycle seconds event on clk_rtc |
| time_q | output | DW | Committed time-count register |
| alarm_q | output | DW | Committed alarm register |
| ctrl_q | output | DW | Committed control register |
| switch_q | output | DW | Committed switch register |
| osc_down | output | 1 | Control register bit PDN_BIT |
| osc_ready | output | 1 | Oscillator seen running for a full tick |

## Verification
The two functions that can meet on one tick are the control commit that clears power-down and a time-count commit that is still under the old power-down rule. The bench posts a control write of zero and a time-count write together, then gives a single tick. It judges the result at the ports: the control register and `osc_down` change, the time-count register keeps its old value, and both pending bits clear. A second case lets several targets commit on one tick and checks that every register takes its own value.

// File: rtl/rtc_pw_pkg.sv
// Package: shared target encoding and slot count for the posted write controller.
// Assumes the select field is two bits wide and that each code names one target.
package rtc_pw_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SEL_W     = $clog2(NUM_SLOTS);

    typedef enum logic [SEL_W-1:0] {
        SLOT_TIME   = 2'd0,
        SLOT_ALARM  = 2'd1,
        SLOT_CTRL   = 2'd2,
        SLOT_SWITCH = 2'd3
    } slot_e;
endpackage

// File: rtl/rtc_pw_sync2.sv
// Two-flop synchronizer for a vector of independent toggle levels.
// Assumes each bit changes at most once per several destination cycles.
module rtc_pw_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtc_pw_core_slot.sv
// Core-side posting slot for one target register.
// Pending is the mismatch between the local request toggle and the returned
// acknowledge toggle. The holding register is loaded only on acceptance and
// then stays stable until the acknowledge comes back.
module rtc_pw_core_slot #(
    parameter int                             DW   = 32,
    parameter logic [rtc_pw_pkg::SEL_W-1:0]   SLOT = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [rtc_pw_pkg::SEL_W-1:0]    wr_sel,
    input  logic [DW-1:0]                   wr_data,
    input  logic                            ack_sync,
    output logic                            req_tog,
    output logic [DW-1:0]                   hold_q,
    output logic                            pending
);
    logic accept;

    // Accept only when addressed and no earlier write is still in flight
    always_comb begin
        pending = req_tog ^ ack_sync;
        accept  = wr_en && (wr_sel == SLOT) && !pending;
    end

    // Capture data and flip the request toggle on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tog <= 1'b0;
            hold_q  <= '0;
        end else if (accept) begin
            req_tog <= ~req_tog;
            hold_q  <= wr_data;
        end
    end
endmodule

// File: rtl/rtc_pw_commit.sv
// RTC-domain register file and commit engine.
// A request is live while its synchronized toggle differs from the local
// acknowledge toggle. Live requests are retired only on sec_tick. Power-down
// and oscillator-startup rules decide whether a retirement writes the register.
// Assumes the holding data has been stable since before the request toggle
// reached this domain.
module rtc_pw_commit #(
    parameter int DW      = 32,
    parameter int PDN_BIT = 0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   sec_tick,
    input  logic [rtc_pw_pkg::NUM_SLOTS-1:0]       req_sync,
    input  logic [rtc_pw_pkg::NUM_SLOTS*DW-1:0]    hold_flat,
    output logic [rtc_pw_pkg::NUM_SLOTS-1:0]       ack_tog,
    output logic [DW-1:0]                          time_q,
    output logic [DW-1:0]                          alarm_q,
    output logic [DW-1:0]                          ctrl_q,
    output logic [DW-1:0]                          switch_q,
    output logic                                   ready_q
);
    import rtc_pw_pkg::*;

    localparam logic [DW-1:0] CTRL_RST = DW'(1) << PDN_BIT;

    logic [NUM_SLOTS-1:0] live;
    logic [NUM_SLOTS-1:0] retire;
    logic [NUM_SLOTS-1:0] commit;
    logic [DW-1:0]        hold [NUM_SLOTS];
    logic                 pdn_now;
    logic                 ready_d;

    // Unpack the per-slot holding data
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign hold[g] = hold_flat[g*DW +: DW];
    end

    // Decide which live requests retire on this tick and which write
    always_comb begin
        pdn_now = ctrl_q[PDN_BIT];
        live    = req_sync ^ ack_tog;
        retire  = '0;
        commit  = '0;
        retire[SLOT_CTRL]   = live[SLOT_CTRL] && sec_tick;
        commit[SLOT_CTRL]   = retire[SLOT_CTRL];
        retire[SLOT_SWITCH] = live[SLOT_SWITCH] && sec_tick;
        commit[SLOT_SWITCH] = retire[SLOT_SWITCH] && !pdn_now;
        retire[SLOT_TIME]   = live[SLOT_TIME] && sec_tick && (pdn_now || ready_q);
        commit[SLOT_TIME]   = retire[SLOT_TIME] && !pdn_now;
        retire[SLOT_ALARM]  = live[SLOT_ALARM] && sec_tick && (pdn_now || ready_q);
        commit[SLOT_ALARM]  = retire[SLOT_ALARM] && !pdn_now;
        ready_d = !pdn_now && !(commit[SLOT_CTRL] && hold[SLOT_CTRL][PDN_BIT]);
    end

    // Apply commits and acknowledge every retired request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_tog  <= '0;
            time_q   <= '0;
            alarm_q  <= '0;
            ctrl_q   <= CTRL_RST;
            switch_q <= '0;
            ready_q  <= 1'b0;
        end else begin
            ack_tog <= ack_tog ^ retire;
            if (commit[SLOT_TIME])   time_q   <= hold[SLOT_TIME];
            if (commit[SLOT_ALARM])  alarm_q  <= hold[SLOT_ALARM];
            if (commit[SLOT_CTRL])   ctrl_q   <= hold[SLOT_CTRL];
            if (commit[SLOT_SWITCH]) switch_q <= hold[SLOT_SWITCH];
            if (sec_tick)            ready_q  <= ready_d;
        end
    end
endmodule

// File: rtl/rtc_posted_write.sv
// Top: posts core writes into the RTC domain through per-target toggle
// handshakes and exposes pending status on the core side.
// Assumes clk_rtc is much slower than clk_core and sec_tick is a one-cycle pulse.
module rtc_posted_write #(
    parameter int DW      = 32,
    parameter int PDN_BIT = 0
) (
    input  logic                          clk_core,
    input  logic                          rst_core_n,
    input  logic                          wr_en,
    input  logic [rtc_pw_pkg::SEL_W-1:0]  wr_sel,
    input  logic [DW-1:0]                 wr_data,
    output logic [rtc_pw_pkg::NUM_SLOTS-1:0] pend_mask,
    output logic                          wr_busy,
    input  logic                          clk_rtc,
    input  logic                          rst_rtc_n,
    input  logic                          sec_tick,
    output logic [DW-1:0]                 time_q,
    output logic [DW-1:0]                 alarm_q,
    output logic [DW-1:0]                 ctrl_q,
    output logic [DW-1:0]                 switch_q,
    output logic                          osc_down,
    output logic                          osc_ready
);
    import rtc_pw_pkg::*;

    logic [NUM_SLOTS-1:0]    req_tog;
    logic [NUM_SLOTS-1:0]    req_sync;
    logic [NUM_SLOTS-1:0]    ack_tog;
    logic [NUM_SLOTS-1:0]    ack_sync;
    logic [NUM_SLOTS*DW-1:0] hold_flat;

    // One posting slot per target register
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rtc_pw_core_slot #(
            .DW   (DW),
            .SLOT (SEL_W'(g))
        ) u_slot (
            .clk      (clk_core),
            .rst_n    (rst_core_n),
            .wr_en    (wr_en),
            .wr_sel   (wr_sel),
            .wr_data  (wr_data),
            .ack_sync (ack_sync[g]),
            .req_tog  (req_tog[g]),
            .hold_q   (hold_flat[g*DW +: DW]),
            .pending  (pend_mask[g])
        );
    end

    rtc_pw_sync2 #(.W(NUM_SLOTS)) u_req_sync (
        .clk   (clk_rtc),
        .rst_n (rst_rtc_n),
        .d     (req_tog),
        .q     (req_sync)
    );

    rtc_pw_sync2 #(.W(NUM_SLOTS)) u_ack_sync (
        .clk   (clk_core),
        .rst_n (rst_core_n),
        .d     (ack_tog),
        .q     (ack_sync)
    );

    rtc_pw_commit #(.DW(DW), .PDN_BIT(PDN_BIT)) u_commit (
        .clk       (clk_rtc),
        .rst_n     (rst_rtc_n),
        .sec_tick  (sec_tick),
        .req_sync  (req_sync),
        .hold_flat (hold_flat),
        .ack_tog   (ack_tog),
        .time_q    (time_q),
        .alarm_q   (alarm_q),
        .ctrl_q    (ctrl_q),
        .switch_q  (switch_q),
        .ready_q   (osc_ready)
    );

    // Core-side busy flag and the power-down view
    assign wr_busy  = |pend_mask;
    assign osc_down = ctrl_q[PDN_BIT];
endmodule

// File: rtl/rtc_posted_write_chk.sv
// Checker bound to rtc_posted_write: temporal rules of posting and committing.
module rtc_posted_write_chk #(
    parameter int DW = 32
) (
    input logic                                clk_core,
    input logic                                rst_core_n,
    input logic                                wr_en,
    input logic [rtc_pw_pkg::SEL_W-1:0]        wr_sel,
    input logic [rtc_pw_pkg::NUM_SLOTS-1:0]    pend_mask,
    input logic [rtc_pw_pkg::NUM_SLOTS*DW-1:0] hold_flat,
    input logic                                clk_rtc,
    input logic                                rst_rtc_n,
    input logic                                sec_tick,
    input logic [DW-1:0]                       time_q,
    input logic [DW-1:0]                       alarm_q,
    input logic [DW-1:0]                       ctrl_q,
    input logic [DW-1:0]                       switch_q,
    input logic                                osc_down,
    input logic                                osc_ready
);
    import rtc_pw_pkg::*;

    // R2: an accepted write raises its pending bit next cycle
    a_r2_post_sets_pending: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        (wr_en && !pend_mask[wr_sel]) |=> pend_mask[$past(wr_sel)]);

    // R3: holding data does not move while its write stays in flight
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hold
        a_r3_hold_stable: assert property (@(posedge clk_core) disable iff (!rst_core_n)
            (pend_mask[g] && $past(pend_mask[g])) |-> $stable(hold_flat[g*DW +: DW]));
    end

    // R4: registers move only on a tick
    a_r4_tick_only: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        !sec_tick |=> $stable({time_q, alarm_q, ctrl_q, switch_q}));

    // R5: powered down, a tick leaves the data registers alone
    a_r5_pdn_blocks: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        (osc_down && sec_tick) |=> $stable({time_q, alarm_q, switch_q}));

    // R6: no time or alarm commit before the oscillator is ready
    a_r6_wait_ready: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        !osc_ready |=> $stable({time_q, alarm_q}));

    // R6: readiness only rises on a tick
    a_r6_ready_on_tick: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        (!sec_tick && !osc_ready) |=> !osc_ready);
endmodule

bind rtc_posted_write rtc_posted_write_chk #(.DW(DW)) u_chk (
    .clk_core   (clk_core),
    .rst_core_n (rst_core_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .pend_mask  (pend_mask),
    .hold_flat  (hold_flat),
    .clk_rtc    (clk_rtc),
    .rst_rtc_n  (rst_rtc_n),
    .sec_tick   (sec_tick),
    .time_q     (time_q),
    .alarm_q    (alarm_q),
    .ctrl_q     (ctrl_q),
    .switch_q   (switch_q),
    .osc_down   (osc_down),
    .osc_ready  (osc_ready)
);

// File: tb/rtc_posted_write_test.sv
module rtc_posted_write_test;
    localparam int DW = 32;

    logic          clk_core = 0, clk_rtc = 0;
    logic          rst_core_n = 0, rst_rtc_n = 0;
    logic          wr_en = 0;
    logic [1:0]    wr_sel = 0;
    logic [DW-1:0] wr_data = 0;
    logic [3:0]    pend_mask;
    logic          wr_busy, sec_tick = 0, osc_down, osc_ready;
    logic [DW-1:0] time_q, alarm_q, ctrl_q, switch_q;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk_core = ~clk_core;
    always #25  clk_rtc  = ~clk_rtc;

    rtc_posted_write #(.DW(DW), .PDN_BIT(0)) uut (.*);

    typedef struct packed { logic [1:0] sel; logic [DW-1:0] data; } vec_t;
    localparam vec_t VEC [6] = '{
        '{2'd0, 32'h0001_2345}, '{2'd1, 32'h0000_0E10}, '{2'd3, 32'h0000_00C3},
        '{2'd2, 32'h0000_00A0}, '{2'd0, 32'hFFFF_FFFE}, '{2'd1, 32'h8000_0001}};

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic post(input logic [1:0] sel, input logic [DW-1:0] data);
        @(negedge clk_core);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk_core);
        wr_en = 0;
    endtask

    task automatic tick();
        repeat (4) @(negedge clk_rtc);
        sec_tick = 1;
        @(negedge clk_rtc);
        sec_tick = 0;
        repeat (2) @(negedge clk_rtc);
    endtask

    function automatic logic [DW-1:0] reg_of(input logic [1:0] sel);
        case (sel)
            2'd0: return time_q;
            2'd1: return alarm_q;
            2'd2: return ctrl_q;
            default: return switch_q;
        endcase
    endfunction

    initial begin
        #150_000;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        n_run++; n_fail++;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_rtc);
        rst_core_n = 1; rst_rtc_n = 1;
        @(negedge clk_core);
        // R1 reset state
        check(time_q == 0 && alarm_q == 0 && switch_q == 0, "R1 data regs", time_q, 0);
        check(ctrl_q == 32'h1 && osc_down && !osc_ready, "R1 ctrl", ctrl_q, 32'h1);
        check(pend_mask == 0 && !wr_busy, "R1 pending", {28'd0, pend_mask}, 0);

        // R5 powered down: time write retired without effect; R2 R8 pending bit 0
        post(2'd0, 32'h55);
        check(pend_mask == 4'b0001 && wr_busy, "R2 R8 pend time", {28'd0, pend_mask}, 1);
        tick();
        check(time_q == 0, "R5 time blocked", time_q, 0);
        check(pend_mask == 0, "R5 retired", {28'd0, pend_mask}, 0);

        // R5 R9 same tick: ctrl clears power-down, time write still dropped
        post(2'd2, 32'h0);
        post(2'd0, 32'h66);
        check(pend_mask == 4'b0101, "R8 pend ctrl+time", {28'd0, pend_mask}, 4'b0101);
        tick();
        check(ctrl_q == 0 && !osc_down, "R9 ctrl committed", ctrl_q, 0);
        check(time_q == 0, "R5 same-tick drop", time_q, 0);
        check(pend_mask == 0, "R5 both retired", {28'd0, pend_mask}, 0);

        // R6 startup: first tick holds time write, second commits
        check(!osc_ready, "R6 not ready", {31'd0, osc_ready}, 0);
        post(2'd0, 32'h77);
        tick();
        check(time_q == 0 && pend_mask == 4'b0001, "R6 held", time_q, 0);
        check(osc_ready, "R6 ready set", {31'd0, osc_ready}, 1);
        tick();
        check(time_q == 32'h77 && pend_mask == 0, "R6 committed", time_q, 32'h77);

        // R4 table walk: each write pends then commits on one tick
        for (int i = 0; i < 6; i++) begin
            post(VEC[i].sel, VEC[i].data);
            check(pend_mask[VEC[i].sel], "R2 table pend", {28'd0, pend_mask}, 0);
            tick();
            check(reg_of(VEC[i].sel) == VEC[i].data, "R4 table commit",
                  reg_of(VEC[i].sel), VEC[i].data);
            check(pend_mask == 0, "R4 table retired", {28'd0, pend_mask}, 0);
        end

        // R3 repeat write dropped
        post(2'd1, 32'h11);
        post(2'd1, 32'h22);
        tick();
        check(alarm_q == 32'h11, "R3 first value kept", alarm_q, 32'h11);

        // R7 concurrent targets
        post(2'd0, 32'hC1);
        post(2'd1, 32'hA1);
        post(2'd3, 32'h51);
        check(pend_mask == 4'b1011 && wr_busy, "R7 pend", {28'd0, pend_mask}, 4'b1011);
        tick();
        check(time_q == 32'hC1 && alarm_q == 32'hA1 && switch_q == 32'h51,
              "R7 all commit", switch_q, 32'h51);

        // R4 no tick: stays pending, register unchanged
        post(2'd3, 32'h99);
        repeat (20) @(negedge clk_rtc);
        check(pend_mask == 4'b1000 && switch_q == 32'h51, "R4 waits for tick", switch_q, 32'h51);
        tick();
        check(switch_q == 32'h99, "R4 late commit", switch_q, 32'h99);

        // R5 R6 power down again
        post(2'd2, 32'h1);
        tick();
        check(osc_down && !osc_ready, "R6 ready cleared", {31'd0, osc_ready}, 0);
        post(2'd1, 32'h33);
        tick();
        check(alarm_q == 32'hA1 && pend_mask == 0, "R5 alarm blocked", alarm_q, 32'hA1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule